// File: doc/BRIEF.md
# Oversampling Accumulator with Tagged Result Word

This block sits behind a 10-bit sampling converter. It gathers a window of raw samples, each with a 4-bit channel number. For each window it forms a single result by summing the samples and shifting the sum right. The block supports four resolution settings:

- **Plain 10-bit**: one sample per result, no shift.
- **Reduced 8-bit**: one sample per result, top eight bits kept.
- **11-bit**: four samples per result, sum shifted right by one.
- **12-bit**: sixteen samples per result, sum shifted right by two.

Because 4^n samples are summed but the sum is shifted only by n, the largest result of an oversampled window falls slightly below the nominal full scale of that resolution.

Each result is placed right-aligned in a 16-bit word. When tagging is on, the channel number of the window's last sample fills the top four bits. The word is held in a last-result register. A one-cycle transfer request, meant for a downstream memory-moving reader, is raised in the same cycle that the register takes a new word.

Top module: `osa_tagged_accum`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `last_word` is 0 and `xfer_req` is 0.
- R2: With `osr_mode` = 0 (plain), every accepted sample is stored as its own result. `last_word[9:0]` equals the sample, the bits above it are zero when untagged, and the word is visible on the clock edge that accepts the sample.
- R3: With `osr_mode` = 3 (reduced 8-bit), every accepted sample is stored as its own result with value `sample >> 2`. A full-scale input gives 255.
- R4: With `osr_mode` = 1, four accepted samples form one result equal to `(sum of the four) >> 1`. Four full-scale samples give 2046.
- R5: With `osr_mode` = 2, sixteen accepted samples form one result equal to `(sum of the sixteen) >> 2`. Sixteen full-scale samples give 4092.
- R6: Cycles with `sample_valid` low do not count toward a window. `xfer_req` is high for exactly the one cycle after the edge that accepts a window's final sample and is low otherwise.
- R7: `last_word` changes only in a cycle where `xfer_req` is high, and it holds its value between results.
- R8: The result value occupies bits [11:0] of the word. With `tag_en` high, bits [15:12] hold the channel number of the window's final sample; with `tag_en` low, bits [15:12] are zero.
- R9: If `osr_mode` differs from its value in the previous cycle, the partial sum and sample count are discarded. A sample accepted in that same cycle is the first sample of the new window.
- R10: `tag_en` and the channel number are taken from the cycle that accepts the final sample of a window. Their values during earlier samples have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| osr_mode | input | 2 | Resolution setting: 0 plain, 1 four-sample, 2 sixteen-sample, 3 reduced 8-bit |
| tag_en | input | 1 | Place the channel number in the word's top four bits |
| sample_valid | input | 1 | A raw sample is offered this cycle |
| sample_data | input | 10 | Raw converter sample |
| sample_chan | input | 4 | Channel number of the sample |
| last_word | output | 16 | Last stored result word |
| xfer_req | output | 1 | One-cycle request: a new word is in `last_word` |

## Verification
Constant full-scale bursts in each mode check the below-full-scale maxima (1023, 255, 2046, 4092); these values would expose an off-by-one shift or sample count. Bursts with idle gaps between samples separate counting of accepted samples from counting of clock cycles. A mode switch in the middle of a window, followed by a clean window, shows whether a stale partial sum leaks into the next result. Channel numbers and tag enable that vary within a window, plus a long random stream with occasional mode changes checked every cycle against a behavioural model, confirm that the tag comes from the final sample and that the word holds between results.

// File: rtl/osa_pkg.sv
package osa_pkg;

    typedef enum logic [1:0] {
        OSR_PLAIN = 2'd0,
        OSR_X4    = 2'd1,
        OSR_X16   = 2'd2,
        OSR_LOW8  = 2'd3
    } osr_mode_e;

    // Default geometry of the block
    localparam int unsigned SAMPLE_W_DEF = 10;
    localparam int unsigned CHAN_W_DEF   = 4;
    localparam int unsigned WORD_W_DEF   = 16;
    localparam int unsigned MAX_LOG4_DEF = 2;

endpackage

// File: rtl/osa_ratio_decode.sv
module osa_ratio_decode
    import osa_pkg::*;
#(
    parameter int unsigned MAX_LOG4 = MAX_LOG4_DEF,
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned SH_W     = 3
) (
    input  osr_mode_e        mode,
    output logic [CNT_W-1:0] last_idx,
    output logic [SH_W-1:0]  shift
);
    // Window length minus one for a window of 4^k samples
    function automatic logic [CNT_W-1:0] idx_of(input int unsigned k);
        logic [CNT_W:0] full;
        full = ({{CNT_W{1'b0}}, 1'b1} << (2 * k)) - 1'b1;
        return full[CNT_W-1:0];
    endfunction

    always_comb begin
        last_idx = '0;
        shift    = '0;
        unique case (mode)
            OSR_PLAIN: begin
                last_idx = '0;
                shift    = '0;
            end
            OSR_X4: begin
                last_idx = idx_of(1);
                shift    = SH_W'(1);
            end
            OSR_X16: begin
                last_idx = idx_of(MAX_LOG4);
                shift    = SH_W'(MAX_LOG4);
            end
            OSR_LOW8: begin
                last_idx = '0;
                shift    = SH_W'(2);
            end
            default: begin
                last_idx = '0;
                shift    = '0;
            end
        endcase
    end
endmodule

// File: rtl/osa_accum.sv
module osa_accum
    import osa_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
    parameter int unsigned CHAN_W   = CHAN_W_DEF,
    parameter int unsigned ACC_W    = 14,
    parameter int unsigned CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  osr_mode_e         mode,
    input  logic [CNT_W-1:0]  last_idx,
    input  logic              in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic              win_done,
    output logic [ACC_W-1:0]  win_sum
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        osr_mode_e        mode_seen;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [ACC_W-1:0] base_acc;
    logic [CNT_W-1:0] base_cnt;
    logic [ACC_W-1:0] total;
    logic             restart;

    always_comb begin
        st_d     = st_q;
        restart  = (mode != st_q.mode_seen);
        base_acc = restart ? '0 : st_q.acc;
        base_cnt = restart ? '0 : st_q.cnt;
        total    = base_acc + ACC_W'(in_data);
        win_done = 1'b0;
        win_sum  = total;

        st_d.mode_seen = mode;
        st_d.acc       = base_acc;
        st_d.cnt       = base_cnt;

        if (in_valid) begin
            if (base_cnt == last_idx) begin
                win_done  = 1'b1;
                st_d.acc  = '0;
                st_d.cnt  = '0;
            end else begin
                st_d.acc  = total;
                st_d.cnt  = base_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc       <= '0;
            st_q.cnt       <= '0;
            st_q.mode_seen <= OSR_PLAIN;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/osa_word_pack.sv
module osa_word_pack #(
    parameter int unsigned ACC_W  = 14,
    parameter int unsigned CHAN_W = 4,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned SH_W   = 3
) (
    input  logic [ACC_W-1:0]  sum,
    input  logic [SH_W-1:0]   shift,
    input  logic [CHAN_W-1:0] chan,
    input  logic              tag_en,
    output logic [WORD_W-1:0] word
);
    localparam int unsigned VALUE_W = WORD_W - CHAN_W;

    logic [ACC_W-1:0]   shifted;
    logic [VALUE_W-1:0] value;

    always_comb begin
        shifted = sum >> shift;
        value   = shifted[VALUE_W-1:0];
        word    = {(tag_en ? chan : {CHAN_W{1'b0}}), value};
    end
endmodule

// File: rtl/osa_tagged_accum.sv
module osa_tagged_accum
    import osa_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
    parameter int unsigned CHAN_W   = CHAN_W_DEF,
    parameter int unsigned WORD_W   = WORD_W_DEF,
    parameter int unsigned MAX_LOG4 = MAX_LOG4_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          osr_mode,
    input  logic                tag_en,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    input  logic [CHAN_W-1:0]   sample_chan,
    output logic [WORD_W-1:0]   last_word,
    output logic                xfer_req
);
    localparam int unsigned ACC_W = SAMPLE_W + 2 * MAX_LOG4;
    localparam int unsigned CNT_W = (2 * MAX_LOG4 > 0) ? 2 * MAX_LOG4 : 1;
    localparam int unsigned SH_W  = $clog2(MAX_LOG4 + 3);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              req;
    } out_state_t;

    out_state_t out_d, out_q;

    osr_mode_e         mode;
    logic [CNT_W-1:0]  last_idx;
    logic [SH_W-1:0]   shift;
    logic              win_done;
    logic [ACC_W-1:0]  win_sum;
    logic [WORD_W-1:0] packed_word;

    assign mode = osr_mode_e'(osr_mode);

    osa_ratio_decode #(
        .MAX_LOG4 (MAX_LOG4),
        .CNT_W    (CNT_W),
        .SH_W     (SH_W)
    ) decode_i (
        .mode     (mode),
        .last_idx (last_idx),
        .shift    (shift)
    );

    osa_accum #(
        .SAMPLE_W (SAMPLE_W),
        .CHAN_W   (CHAN_W),
        .ACC_W    (ACC_W),
        .CNT_W    (CNT_W)
    ) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .last_idx (last_idx),
        .in_valid (sample_valid),
        .in_data  (sample_data),
        .win_done (win_done),
        .win_sum  (win_sum)
    );

    osa_word_pack #(
        .ACC_W  (ACC_W),
        .CHAN_W (CHAN_W),
        .WORD_W (WORD_W),
        .SH_W   (SH_W)
    ) pack_i (
        .sum    (win_sum),
        .shift  (shift),
        .chan   (sample_chan),
        .tag_en (tag_en),
        .word   (packed_word)
    );

    always_comb begin
        out_d     = out_q;
        out_d.req = win_done;
        if (win_done) begin
            out_d.word = packed_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign last_word = out_q.word;
    assign xfer_req  = out_q.req;
endmodule

// File: rtl/osa_tagged_accum_chk.sv
module osa_tagged_accum_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  osr_mode,
    input logic        tag_en,
    input logic        sample_valid,
    input logic [9:0]  sample_data,
    input logic [3:0]  sample_chan,
    input logic [15:0] last_word,
    input logic        xfer_req
);
    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_req |-> $stable(last_word));

    // R6
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> $past(sample_valid));

    // R8
    untagged_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !$past(tag_en)) |-> (last_word[15:12] == 4'd0));

    // R8
    tag_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && $past(tag_en)) |-> (last_word[15:12] == $past(sample_chan)));

    // R5
    range_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_word[11:0] <= 12'd4092);

    // R2
    plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && $past(osr_mode) == 2'd0)
            |-> (last_word[11:0] == {2'b00, $past(sample_data)}));

    // R3
    low8_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && $past(osr_mode) == 2'd3) |-> (last_word[11:0] <= 12'd255));
endmodule

bind osa_tagged_accum osa_tagged_accum_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .osr_mode     (osr_mode),
    .tag_en       (tag_en),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .sample_chan  (sample_chan),
    .last_word    (last_word),
    .xfer_req     (xfer_req)
);

// File: tb/osa_tagged_accum_tb.sv
`timescale 1ns/1ps
module osa_tagged_accum_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  osr_mode = 2'd0;
    logic        tag_en = 1'b0;
    logic        sample_valid = 1'b0;
    logic [9:0]  sample_data = '0;
    logic [3:0]  sample_chan = '0;
    logic [15:0] last_word;
    logic        xfer_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // reference model state
    int m_acc = 0;
    int m_cnt = 0;
    int m_prev = 0;
    int exp_word = 0;
    bit exp_req = 0;

    always #5 clk = ~clk;

    osa_tagged_accum dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .osr_mode     (osr_mode),
        .tag_en       (tag_en),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .sample_chan  (sample_chan),
        .last_word    (last_word),
        .xfer_req     (xfer_req)
    );

    // Behavioural model, evaluated on each rising edge with the settled inputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 0; m_cnt = 0; m_prev = 0; exp_word = 0; exp_req = 0;
        end else begin
            int n, v, sh;
            exp_req = 0;
            if (int'(osr_mode) != m_prev) begin
                m_acc = 0; m_cnt = 0;
            end
            m_prev = int'(osr_mode);
            if (sample_valid) begin
                n  = (osr_mode == 2'd1) ? 4 : (osr_mode == 2'd2) ? 16 : 1;
                sh = (osr_mode == 2'd1) ? 1 : (osr_mode == 2'd2) ? 2 : 0;
                v  = (osr_mode == 2'd3) ? int'(sample_data) / 4 : int'(sample_data);
                m_acc = m_acc + v;
                m_cnt = m_cnt + 1;
                if (m_cnt == n) begin
                    exp_word = (tag_en ? int'(sample_chan) * 4096 : 0) + (m_acc >> sh);
                    exp_req  = 1;
                    m_acc = 0; m_cnt = 0;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            string tag;
            case (m_prev)
                0: tag = "R2";
                1: tag = "R4";
                2: tag = "R5";
                default: tag = "R3";
            endcase
            check({tag, "/R6 xfer_req"}, int'(xfer_req), int'(exp_req));
            check({tag, "/R7/R8 last_word"}, int'(last_word), exp_word);
        end
        if (cyc == 150000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Offer one sample; returns at the next falling edge, after the accepting edge
    task automatic send(input int d, input int ch);
        sample_valid = 1'b1;
        sample_data  = 10'(d);
        sample_chan  = 4'(ch);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        check("R1 reset word", int'(last_word), 0);
        check("R1 reset req", int'(xfer_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 word after release", int'(last_word), 0);
        check("R1 req after release", int'(xfer_req), 0);

        // R2 plain mode
        osr_mode = 2'd0;
        send(1023, 1);
        check("R2 full scale", int'(last_word), 1023);
        check("R2 req", int'(xfer_req), 1);
        send(5, 2);
        check("R2 small", int'(last_word), 5);

        // R3 reduced mode
        osr_mode = 2'd3;
        send(1023, 0);
        check("R3 full scale", int'(last_word), 255);
        send(7, 0);
        check("R3 small", int'(last_word), 1);

        // R4 four-sample mode
        osr_mode = 2'd1;
        idle(1);
        for (int i = 0; i < 3; i++) send(1023, 0);
        check("R6 no req before window end", int'(xfer_req), 0);
        send(1023, 0);
        check("R4 full scale 2046", int'(last_word), 2046);
        check("R6 req at window end", int'(xfer_req), 1);
        idle(1);
        check("R6 req one cycle", int'(xfer_req), 0);

        // R6 idle gaps do not count
        send(10, 0); idle(3);
        send(20, 0); idle(2);
        send(30, 0); idle(4);
        check("R6 gaps no req", int'(last_word), 2046);
        send(41, 0);
        check("R6 gapped window", int'(last_word), 50);

        // R5 sixteen-sample mode
        osr_mode = 2'd2;
        idle(1);
        for (int i = 0; i < 16; i++) send(1023, 0);
        check("R5 full scale 4092", int'(last_word), 4092);

        // R7 hold
        idle(5);
        check("R7 hold", int'(last_word), 4092);

        // R8 and R10 tag from final sample
        osr_mode = 2'd1;
        idle(1);
        tag_en = 1'b0;
        send(100, 3); send(100, 4); send(100, 5);
        tag_en = 1'b1;
        send(100, 9);
        check("R10 tag from final cycle", int'(last_word), 9 * 4096 + 200);
        tag_en = 1'b1;
        send(4, 15); send(4, 15); send(4, 15);
        tag_en = 1'b0;
        send(4, 15);
        check("R8 untagged top zero", int'(last_word), 8);

        // R9 mode change discards partial sum
        send(1000, 0); send(1000, 0);
        osr_mode = 2'd0;
        send(7, 0);
        check("R9 switch sample starts new window", int'(last_word), 7);
        osr_mode = 2'd1;
        for (int i = 0; i < 4; i++) send(100, 0);
        check("R9 no stale sum", int'(last_word), 200);

        // Random stream checked by the per-cycle model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 99) < 3) osr_mode = 2'($urandom_range(0, 3));
            tag_en       = 1'($urandom_range(0, 1));
            sample_valid = ($urandom_range(0, 3) != 0);
            sample_data  = 10'($urandom_range(0, 1023));
            sample_chan  = 4'($urandom_range(0, 15));
            @(negedge clk);
        end
        sample_valid = 1'b0;
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule